// File: doc/BRIEF.md
# Television-Rate PLL Control Register Block

This block holds the control state of a television-rate clock synthesizer behind a small word-addressed register port. Three 16-bit control words sit at addresses 0, 1 and 2. Every write carries its own bit-enable: the top half of the 32-bit write data selects which of the bottom 16 bits are replaced, so separate agents can change separate fields without a read-modify-write. The stored fields cover power-down, bypass, fractional select, modulus select, phase select, a 7-bit fractional numerator, a 2-bit post-divider exponent and the feedback and input dividers. Both dividers are stored as their value minus one.

Alongside the registers, a small calculator turns the stored fields back into an output frequency in hertz from a 27 MHz reference. It runs after any write to a register and after a start pulse. It uses a bit-serial divider followed by one multiply and a shift. When the result is ready it raises a one-cycle done strobe. In bypass it reports the reference rate. In fractional mode it raises a flag and reports zero instead of a rate.

Top module: `tvpll_ctrl_regs`

## Requirements
- R1: A write to address 0, 1 or 2 replaces stored bit i (0..15) with write-data bit i only when write-data bit i+16 is 1; every other stored bit keeps its value.
- R2: After reset, word 0 reads 0x0001, words 1 and 2 read 0x0000, `rate_out` is 0, `rate_done` is 0 and `frac_mode` is 0.
- R3: A read returns the addressed stored word in bits 15:0 and zeros in bits 31:16. Address 3 reads as zero. A write to address 3 changes no word and starts no calculation.
- R4: In integer mode (word 0 bits 15 and 1 both 0), the reported rate is floor(27000000 / M) × N, shifted right by R and truncated to 32 bits. Here M = word2[14:8] + 1, N = word2[7:0] + 1 and R = word1[8:7].
- R5: When the bypass bit (word 0 bit 15) is 1, the reported rate is 27000000 and `frac_mode` is 0, whatever the fractional select holds.
- R6: When word 0 bit 15 is 0 and the fractional select (word 0 bit 1) is 1, the result carries `frac_mode` = 1 and `rate_out` = 0.
- R7: A `calc_start` pulse or a write to address 0, 1 or 2 launches a calculation. A launch while one is running abandons it, so back-to-back writes yield a single `rate_done`. No `rate_done` appears in the cycle after a launch.
- R8: `rate_done` is high for exactly one cycle per result, and `rate_out` does not change in cycles where `rate_done` is low.
- R9: `pll_enabled` equals word 0 bit 0; a value of 1 means the synthesizer is running.
- R10: `frac_modulus` is 55 when word 0 bit 2 is 1 and 91 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Bit-enable in [31:16], data in [15:0] |
| bus_rdata | output | 32 | Addressed word, upper half zero |
| calc_start | input | 1 | Launch a calculation without a write |
| rate_out | output | 32 | Last computed output rate in hertz |
| rate_done | output | 1 | One-cycle strobe when `rate_out` is fresh |
| frac_mode | output | 1 | Last result was taken in fractional mode |
| pll_enabled | output | 1 | Running flag from word 0 bit 0 |
| frac_modulus | output | 7 | Selected sigma-delta modulus |

## Verification
The bound checker watches several behaviours on every cycle:
- the strobe lasts one cycle, and `rate_out` holds still between strobes;
- no strobe appears right after a launch;
- a fractional result carries a zero rate;
- a word-0 write with its enable bit clear leaves the run flag alone;
- a word-0 write with its enable bit set moves the run flag and the modulus to the written values.

The arithmetic needs the bench's scenarios. It checks truncation in the divide, overflow past 32 bits, each shift amount, and which of bypass and fractional select wins. The scenarios also show that back-to-back writes collapse into one result, that address 3 is inert, and that masked writes read back correctly.

// File: rtl/tvpll_pkg.sv
package tvpll_pkg;
    localparam int WORD_W   = 16;
    localparam int BUS_W    = 32;
    localparam int BIT_RUN  = 0;
    localparam int BIT_FRAC = 1;
    localparam int BIT_MODS = 2;
    localparam int BIT_PHS  = 4;
    localparam int BIT_BYP  = 15;
    localparam int NUM_LO   = 6;
    localparam int NUM_W    = 7;
    localparam int SHR_LO   = 7;
    localparam int SHR_W    = 2;
    localparam int FBD_LO   = 0;
    localparam int FBD_W    = 8;
    localparam int IND_LO   = 8;
    localparam int IND_W    = 7;
    localparam logic [6:0] MOD_HI = 7'd91;
    localparam logic [6:0] MOD_LO = 7'd55;

    typedef enum logic [1:0] {
        CALC_IDLE = 2'd0,
        CALC_LOAD = 2'd1,
        CALC_DIV  = 2'd2
    } calc_state_e;
endpackage

// File: rtl/tvpll_mask_reg.sv
module tvpll_mask_reg #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] wr_enable,
    output logic [W-1:0] word
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = (word_q & ~wr_enable) | (wr_bits & wr_enable);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= RST_VAL;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/tvpll_rate_calc.sv
module tvpll_rate_calc
    import tvpll_pkg::*;
#(
    parameter int unsigned REF_HZ = 27000000,
    parameter int          RATE_W = 32,
    parameter int          M_W    = 7,
    parameter int          N_W    = 8,
    parameter int          R_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              byp,
    input  logic              fra,
    input  logic [M_W-1:0]    m_fld,
    input  logic [N_W-1:0]    n_fld,
    input  logic [R_W-1:0]    r_fld,
    output logic [RATE_W-1:0] rate,
    output logic              done,
    output logic              frac
);
    localparam int CNT_W  = $clog2(RATE_W + 1);
    localparam int REM_W  = M_W + 2;
    localparam int PROD_W = RATE_W + N_W + 1;

    typedef struct packed {
        calc_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [REM_W-1:0] rem;
        logic [RATE_W-1:0] quo;
        logic [M_W:0]     dvs;
        logic [N_W:0]     mul;
        logic [R_W-1:0]   shr;
        logic [RATE_W-1:0] rate;
        logic             done;
        logic             frac;
    } calc_t;

    calc_t s_d, s_q;

    logic [REM_W-1:0]  rem_sh;
    logic [RATE_W-1:0] quo_n;
    logic [PROD_W-1:0] prod;

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        rem_sh = '0;
        quo_n  = '0;
        prod   = '0;
        case (s_q.st)
            CALC_LOAD: begin
                if (byp) begin
                    s_d.rate = RATE_W'(REF_HZ);
                    s_d.frac = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = CALC_IDLE;
                end else if (fra) begin
                    s_d.rate = '0;
                    s_d.frac = 1'b1;
                    s_d.done = 1'b1;
                    s_d.st   = CALC_IDLE;
                end else begin
                    s_d.dvs = {1'b0, m_fld} + 1'b1;
                    s_d.mul = {1'b0, n_fld} + 1'b1;
                    s_d.shr = r_fld;
                    s_d.quo = RATE_W'(REF_HZ);
                    s_d.rem = '0;
                    s_d.cnt = CNT_W'(RATE_W);
                    s_d.st  = CALC_DIV;
                end
            end
            CALC_DIV: begin
                rem_sh = {s_q.rem[REM_W-2:0], s_q.quo[RATE_W-1]};
                if (rem_sh >= REM_W'(s_q.dvs)) begin
                    rem_sh = rem_sh - REM_W'(s_q.dvs);
                    quo_n  = {s_q.quo[RATE_W-2:0], 1'b1};
                end else begin
                    quo_n  = {s_q.quo[RATE_W-2:0], 1'b0};
                end
                s_d.rem = rem_sh;
                s_d.quo = quo_n;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CNT_W'(1)) begin
                    prod     = (PROD_W'(quo_n) * PROD_W'(s_q.mul)) >> s_q.shr;
                    s_d.rate = prod[RATE_W-1:0];
                    s_d.frac = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = CALC_IDLE;
                end
            end
            default: begin
            end
        endcase
        if (go) begin
            s_d.st   = CALC_LOAD;
            s_d.done = 1'b0;
            s_d.rate = s_q.rate;
            s_d.frac = s_q.frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: CALC_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rate = s_q.rate;
    assign done = s_q.done;
    assign frac = s_q.frac;
endmodule

// File: rtl/tvpll_ctrl_regs.sv
module tvpll_ctrl_regs
    import tvpll_pkg::*;
#(
    parameter int unsigned REF_HZ = 27000000,
    parameter int          RATE_W = 32,
    parameter int          NREG   = 3,
    parameter int          ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              calc_start,
    output logic [RATE_W-1:0] rate_out,
    output logic              rate_done,
    output logic              frac_mode,
    output logic              pll_enabled,
    output logic [6:0]        frac_modulus
);
    logic [WORD_W-1:0] words [NREG];
    logic              hit_any;
    logic              launch;

    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic sel;
        assign sel = bus_wr && (bus_addr == ADDR_W'(g));
        tvpll_mask_reg #(
            .W       (WORD_W),
            .RST_VAL ((g == 0) ? 16'h0001 : 16'h0000)
        ) u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel),
            .wr_bits   (bus_wdata[WORD_W-1:0]),
            .wr_enable (bus_wdata[BUS_W-1:WORD_W]),
            .word      (words[g])
        );
    end

    always_comb begin
        hit_any   = 1'b0;
        bus_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata[WORD_W-1:0] = words[i];
                hit_any = bus_wr;
            end
        end
        launch = calc_start | hit_any;
    end

    tvpll_rate_calc #(
        .REF_HZ (REF_HZ),
        .RATE_W (RATE_W),
        .M_W    (IND_W),
        .N_W    (FBD_W),
        .R_W    (SHR_W)
    ) u_calc (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (launch),
        .byp   (words[0][BIT_BYP]),
        .fra   (words[0][BIT_FRAC]),
        .m_fld (words[2][IND_LO +: IND_W]),
        .n_fld (words[2][FBD_LO +: FBD_W]),
        .r_fld (words[1][SHR_LO +: SHR_W]),
        .rate  (rate_out),
        .done  (rate_done),
        .frac  (frac_mode)
    );

    assign pll_enabled  = words[0][BIT_RUN];
    assign frac_modulus = words[0][BIT_MODS] ? MOD_LO : MOD_HI;
endmodule

// File: rtl/tvpll_ctrl_checker.sv
module tvpll_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        calc_start,
    input logic [31:0] rate_out,
    input logic        rate_done,
    input logic        frac_mode,
    input logic        pll_enabled,
    input logic [6:0]  frac_modulus
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R8: strobe lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rate_done |=> !rate_done);

    // R8: result held between strobes
    a_r8_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !rate_done) |-> $stable(rate_out));

    // R7: no strobe right after a launch
    a_r7_launch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_start || (bus_wr && bus_addr != 2'd3)) |=> !rate_done);

    // R6: fractional result carries zero rate
    a_r6_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_done && frac_mode) |-> (rate_out == 32'd0));

    // R1: masked-off bit keeps its value
    a_r1_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !bus_wdata[16]) |=> $stable(pll_enabled));

    // R9: enabled flag follows written bit
    a_r9_run_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[16]) |=> (pll_enabled == $past(bus_wdata[0])));

    // R10: modulus follows written select
    a_r10_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[18])
        |=> (frac_modulus == ($past(bus_wdata[2]) ? 7'd55 : 7'd91)));
endmodule

bind tvpll_ctrl_regs tvpll_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .calc_start   (calc_start),
    .rate_out     (rate_out),
    .rate_done    (rate_done),
    .frac_mode    (frac_mode),
    .pll_enabled  (pll_enabled),
    .frac_modulus (frac_modulus)
);

// File: tb/tb_tvpll_ctrl_regs.sv
module tb_tvpll_ctrl_regs;
    localparam int          CLK_PERIOD = 10;
    localparam int unsigned REF        = 27000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        calc_start = 1'b0;
    logic [31:0] rate_out;
    logic        rate_done;
    logic        frac_mode;
    logic        pll_enabled;
    logic [6:0]  frac_modulus;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    typedef struct {
        logic [31:0] rate;
        bit          frac;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [15:0] mdl [3];

    tvpll_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .calc_start(calc_start),
        .rate_out(rate_out), .rate_done(rate_done), .frac_mode(frac_mode),
        .pll_enabled(pll_enabled), .frac_modulus(frac_modulus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model_result(input string req);
        exp_t e;
        longint unsigned q, p;
        e.req = req;
        if (mdl[0][15]) begin
            e.rate = REF; e.frac = 1'b0;
        end else if (mdl[0][1]) begin
            e.rate = 32'd0; e.frac = 1'b1;
        end else begin
            q = longint'(REF) / (longint'(mdl[2][14:8]) + 1);
            p = q * (longint'(mdl[2][7:0]) + 1);
            p = p >> mdl[1][8:7];
            e.rate = p[31:0]; e.frac = 1'b0;
        end
        return e;
    endfunction

    function automatic void model_write(input logic [1:0] a, input logic [31:0] d);
        if (a < 2'd3) mdl[a] = (mdl[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endfunction

    // monitor: pops expected result on every strobe
    always @(negedge clk) begin
        if (rst_n && rate_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected rate_done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rate_out == e.rate, e.req, "rate_out", rate_out, e.rate);
                check(frac_mode == e.frac, e.req, "frac_mode", 32'(frac_mode), 32'(e.frac));
            end
        end
    end

    task automatic drain(input string req);
        int t = 0;
        while (sb.size() != 0 && t < 200) begin
            @(negedge clk); t++;
        end
        check(sb.size() == 0, req, "result arrived", 32'(sb.size()), 32'd0);
        sb.delete();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        if (a < 2'd3) begin
            sb.push_back(model_result(req));
            drain(req);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, "read", bus_rdata, exp);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk); cycles++;
        end
        check(1'b0, "WD", "watchdog expired", 32'(cycles), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        mdl[0] = 16'h0001; mdl[1] = 16'h0000; mdl[2] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        rd(2'd0, 32'h0000_0001, "R2");
        rd(2'd1, 32'h0, "R2");
        rd(2'd2, 32'h0, "R2");
        check(rate_out == 0, "R2", "rate_out", rate_out, 0);
        check(rate_done == 0 && frac_mode == 0, "R2", "done/frac", {30'b0, rate_done, frac_mode}, 0);
        check(pll_enabled == 1'b1, "R9", "reset enabled", 32'(pll_enabled), 1);
        check(frac_modulus == 7'd91, "R10", "reset modulus", 32'(frac_modulus), 91);

        // R4 integer cases (M=1,N=1,R=0 -> 27000000)
        wr(2'd2, 32'hFFFF_0000, "R4");
        wr(2'd2, 32'hFFFF_020A, "R4");   // M=3, N=11
        wr(2'd1, 32'h0180_0080, "R4");   // R=1
        wr(2'd2, 32'hFFFF_0663, "R4");   // M=7 truncating divide
        wr(2'd1, 32'h0180_0180, "R4");   // R=3
        wr(2'd2, 32'hFFFF_7FC7, "R4");   // M=128
        wr(2'd1, 32'h0180_0000, "R4");
        wr(2'd2, 32'hFFFF_00FF, "R4");   // N=256, overflow past 32 bits

        // R7 start pulse relaunch
        @(negedge clk); calc_start = 1'b1;
        @(negedge clk); calc_start = 1'b0;
        sb.push_back(model_result("R7"));
        drain("R7");

        // R7 back-to-back writes give one result
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'hFFFF_0104;
        model_write(2'd2, bus_wdata);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 32'h0180_0100;
        model_write(2'd1, bus_wdata);
        @(negedge clk); bus_wr = 1'b0;
        sb.push_back(model_result("R7"));
        drain("R7");
        repeat (60) @(negedge clk);

        // R8 hold between strobes
        held = rate_out;
        repeat (20) @(negedge clk);
        check(rate_out == held, "R8", "rate held", rate_out, held);

        // R5 bypass, also with fractional select
        wr(2'd0, 32'h8000_8000, "R5");
        wr(2'd0, 32'h0002_0002, "R5");
        // R6 fractional mode
        wr(2'd0, 32'h8000_0000, "R6");
        check(frac_modulus == 7'd91, "R10", "modulus 91", 32'(frac_modulus), 91);
        wr(2'd0, 32'h0004_0004, "R10");
        check(frac_modulus == 7'd55, "R10", "modulus 55", 32'(frac_modulus), 55);
        wr(2'd0, 32'h0002_0000, "R4");

        // R1 masked writes with readback
        wr(2'd1, 32'hFFFF_0000, "R1");
        wr(2'd1, 32'h00F0_FFFF, "R1");
        rd(2'd1, 32'h0000_00F0, "R1");
        wr(2'd1, 32'h0F00_AAAA, "R1");
        rd(2'd1, 32'h0000_0AF0, "R1");
        wr(2'd0, 32'h1FC0_1FC0, "R1");   // numerator all ones
        rd(2'd0, {16'h0, mdl[0]}, "R1");
        check(mdl[0] == 16'h1FC5, "R1", "model word0", 32'(mdl[0]), 32'h1FC5);

        // R9 power down and up
        wr(2'd0, 32'h0001_0000, "R9");
        check(pll_enabled == 1'b0, "R9", "disabled", 32'(pll_enabled), 0);
        wr(2'd0, 32'h0001_0001, "R9");
        check(pll_enabled == 1'b1, "R9", "enabled", 32'(pll_enabled), 1);

        // R3 address 3 is inert
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); bus_wr = 1'b0;
        repeat (60) @(negedge clk);
        rd(2'd3, 32'h0, "R3");
        rd(2'd0, {16'h0, mdl[0]}, "R3");
        rd(2'd1, {16'h0, mdl[1]}, "R3");
        rd(2'd2, {16'h0, mdl[2]}, "R3");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule